// File: doc/BRIEF.md
# Approximate Booth-Recoded Signed Multiplier

This block multiplies two 8-bit two's-complement operands and returns a 16-bit signed product. The product is allowed to miss the exact value by a small, hard-bounded amount, which buys a smaller summation network. The multiplier operand is radix-4 Booth recoded into four digits in {-2, -1, 0, +1, +2}. Each digit selects a multiple of the multiplicand and yields one partial-product row. Negative rows are formed by bit inversion plus a +1 correction bit. Sign extension is replaced by an inverted row sign bit together with one precomputed correction constant.

The two highest rows are added into a single merged row, which also absorbs the correction constant and the +1 bits of the lower rows. The three remaining operands are then reduced one column at a time, from the least significant column upward, with a single count-and-carry per column and no adder tree. Result bits 2 and above are exact, and so is the carry leaving column 1. Bits 1 and 0 are simply taken from row zero, which leaves its +1 correction out of them. The result is registered, carries a valid flag one cycle behind the input flag, and a new operand pair may be presented every cycle.

Top module: `apx_booth_mul`

## Requirements
- R1: While rst is high at a rising clock edge, out_valid and p are cleared to 0 at that edge.
- R2: out_valid is high in exactly the cycle after a cycle with in_valid high and low otherwise, so one operand pair is accepted per cycle with no gap needed.
- R3: For every accepted pair, p[15:2] equals bits 15:2 of the exact 16-bit two's-complement product a*b.
- R4: For every accepted pair, the signed difference p - a*b lies in -3..+3; for a = -128 (0x80) and b = 127 (0x7F) the result is 0xC083 (-16253), three above the exact value.
- R5: p[1:0] equals the two low bits of (a*d - n), where d = b[0] - 2*b[1] is the lowest Booth digit and n = b[1] flags that digit as negative.
- R6: When b[1] = 0, p equals the exact product; for a = b = -128 the result is 0x4000 (16384).
- R7: Averaged over all 65,536 operand pairs, the absolute error |p - a*b| is at most 1.6.
- R8: A cycle with in_valid low leaves p unchanged, whatever values a and b carry.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Marks a and b as an operand pair to multiply |
| a | input | 8 | Multiplicand, two's complement |
| b | input | 8 | Multiplier, two's complement, Booth recoded |
| out_valid | output | 1 | High in the cycle after an accepted pair |
| p | output | 16 | Registered approximate signed product |

## Verification
The exhaustive sweep of all multiplicand and multiplier pairs separates the exact upper bits (R3) from the approximated lower two bits. It checks the lower bits against an independent formula from the first Booth digit (R5) and bounds the error at every pair (R4) and on average (R7). Multipliers with b[1] clear isolate the non-negative first digit, where any error at all points to a fault in the correction path rather than to the intended approximation (R6). The extreme operands -128 x 127 and -128 x -128 exercise the largest Booth multiple, the sign-bit correction constant and the worst carry out of the low columns. An idle cycle after every 256 pairs, with the operands still toggling, separates the valid timing (R2) from the hold of the registered product (R8).

// File: rtl/apx_booth_pkg.sv
`timescale 1ns/1ps
package apx_booth_pkg;

  // Control lines for one radix-4 Booth digit.
  typedef struct packed {
    logic neg;  // digit is negative
    logic one;  // magnitude 1
    logic two;  // magnitude 2
  } booth_ctl_t;

  // Decode an overlapping 3-bit group {upper, middle, lower} into a digit.
  function automatic booth_ctl_t booth_decode(input logic [2:0] grp);
    booth_ctl_t c;
    c.one = grp[1] ^ grp[0];
    c.two = (grp[2] & ~grp[1] & ~grp[0]) | (~grp[2] & grp[1] & grp[0]);
    c.neg = grp[2] & ~(grp[1] & grp[0]);
    return c;
  endfunction

  // Each row carries its sign bit inverted at weight 2^(opw+1+2r).
  // The inversion adds 2^k per row, so subtract the sum of them once.
  function automatic logic [63:0] sign_fix_const(input int unsigned opw);
    logic [63:0] acc;
    acc = '0;
    for (int unsigned r = 0; r < opw / 2; r++) begin
      acc = acc - (64'd1 << (opw + 1 + 2 * r));
    end
    return acc;
  endfunction

endpackage

// File: rtl/apx_booth_row.sv
`timescale 1ns/1ps
module apx_booth_row
  import apx_booth_pkg::*;
#(
  parameter int W   = 8,
  parameter int ROW = 0
) (
  input  logic [W-1:0]   mcand,
  input  logic [2:0]     grp,
  output logic [2*W-1:0] row_bits,
  output logic           neg
);
  localparam int PW = 2 * W;
  localparam int RW = W + 2;   // room for +/-2 times the most negative operand
  localparam int SH = 2 * ROW;

  booth_ctl_t     ctl;
  logic [RW-1:0]  mag;
  logic [RW-1:0]  flip;

  always_comb begin
    ctl = booth_decode(grp);
    mag = '0;
    if (ctl.one) begin
      mag = {{2{mcand[W-1]}}, mcand};
    end else if (ctl.two) begin
      mag = {mcand[W-1], mcand, 1'b0};
    end
    // Negative digits: ones' complement here, +1 injected downstream.
    flip         = mag ^ {RW{ctl.neg}};
    // Sign bit carried inverted; the constant in the merge stage balances it.
    flip[RW-1]   = ~flip[RW-1];
    row_bits     = {{(PW - RW){1'b0}}, flip} << SH;
    neg          = ctl.neg;
  end

endmodule

// File: rtl/apx_booth_merge.sv
`timescale 1ns/1ps
module apx_booth_merge
  import apx_booth_pkg::*;
#(
  parameter int W = 8
) (
  input  logic [W/2-1:0][2*W-1:0] rows,
  input  logic [W/2-1:0]          negs,
  output logic [2*W-1:0]          merged
);
  localparam int PW   = 2 * W;
  localparam int ROWS = W / 2;
  localparam int HI   = ROWS - 1;
  localparam int LO   = ROWS - 2;
  localparam logic [PW-1:0] FIX = PW'(sign_fix_const(W));

  logic [PW-1:0] top_pair;
  logic [PW-1:0] inject;

  // Add the two highest rows, their +1 bits and the sign correction.
  always_comb begin
    top_pair = rows[LO] + rows[HI]
             + (PW'(negs[LO]) << (2 * LO))
             + (PW'(negs[HI]) << (2 * HI))
             + FIX;
  end

  // +1 bits of the lower rows sit in columns the merged row leaves empty.
  genvar gi;
  generate
    for (gi = 0; gi < PW; gi++) begin : g_inj
      if ((gi % 2 == 0) && (gi / 2 < LO)) begin : g_hole
        assign inject[gi] = negs[gi/2];
      end else begin : g_none
        assign inject[gi] = 1'b0;
      end
    end
  endgenerate

  assign merged = top_pair | inject;

endmodule

// File: rtl/apx_booth_colsum.sv
`timescale 1ns/1ps
module apx_booth_colsum #(
  parameter int W    = 8,
  parameter int NOPS = 3,
  parameter int LOW  = 2
) (
  input  logic [NOPS-1:0][2*W-1:0] ops,
  output logic [2*W-1:0]           sum
);
  localparam int PW = 2 * W;
  localparam int CW = $clog2(NOPS + 1) + 1;

  logic [PW:0][CW-1:0] carry;

  assign carry[0] = '0;

  genvar c;
  generate
    for (c = 0; c < PW; c++) begin : g_col
      logic [NOPS-1:0] colv;
      logic [CW-1:0]   cnt;
      for (genvar k = 0; k < NOPS; k++) begin : g_tap
        assign colv[k] = ops[k][c];
      end
      // Exact count of the column plus what rose from below.
      assign cnt          = carry[c] + CW'($countones(colv));
      assign carry[c + 1] = cnt >> 1;
      if (c < LOW) begin : g_apx
        // Cheap bit: row zero alone, its +1 bit left out of the output.
        assign sum[c] = ops[0][c];
      end else begin : g_exact
        assign sum[c] = cnt[0];
      end
    end
  endgenerate

endmodule

// File: rtl/apx_booth_mul.sv
`timescale 1ns/1ps
module apx_booth_mul #(
  parameter int W = 8
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           in_valid,
  input  logic [W-1:0]   a,
  input  logic [W-1:0]   b,
  output logic           out_valid,
  output logic [2*W-1:0] p
);
  localparam int PW   = 2 * W;
  localparam int ROWS = W / 2;
  localparam int NOPS = ROWS - 1;
  localparam int LOW  = 2;

  logic [W:0]                bx;
  logic [ROWS-1:0][PW-1:0]   rows;
  logic [ROWS-1:0]           negs;
  logic [PW-1:0]             merged;
  logic [NOPS-1:0][PW-1:0]   ops;
  logic [PW-1:0]             sum_next;

  assign bx = {b, 1'b0};

  genvar r;
  generate
    for (r = 0; r < ROWS; r++) begin : g_row
      apx_booth_row #(.W(W), .ROW(r)) u_row (
        .mcand   (a),
        .grp     (bx[2*r+2 : 2*r]),
        .row_bits(rows[r]),
        .neg     (negs[r])
      );
    end
    for (r = 0; r < NOPS - 1; r++) begin : g_pass
      assign ops[r] = rows[r];
    end
  endgenerate

  apx_booth_merge #(.W(W)) u_merge (
    .rows  (rows),
    .negs  (negs),
    .merged(merged)
  );

  assign ops[NOPS-1] = merged;

  apx_booth_colsum #(.W(W), .NOPS(NOPS), .LOW(LOW)) u_sum (
    .ops(ops),
    .sum(sum_next)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid <= 1'b0;
      p         <= '0;
    end else begin
      out_valid <= in_valid;
      if (in_valid) begin
        p <= sum_next;
      end
    end
  end

endmodule

// File: rtl/apx_booth_mul_chk.sv
`timescale 1ns/1ps
module apx_booth_mul_chk #(
  parameter int W = 8
) (
  input logic           clk,
  input logic           rst,
  input logic           in_valid,
  input logic [W-1:0]   a,
  input logic [W-1:0]   b,
  input logic           out_valid,
  input logic [2*W-1:0] p,
  input logic [W/2-1:0] row_neg
);
  localparam int PW = 2 * W;

  logic signed [PW-1:0] exact_w;
  assign exact_w = $signed({{W{a[W-1]}}, a}) * $signed({{W{b[W-1]}}, b});

  AST_RESET_CLEAR: assert property (@(posedge clk) disable iff (rst)
    $fell(rst) |-> (!out_valid && p == '0)); // R1

  AST_VALID_FOLLOW: assert property (@(posedge clk) disable iff (rst)
    in_valid |=> out_valid); // R2

  AST_IDLE_LOW: assert property (@(posedge clk) disable iff (rst)
    !in_valid |=> !out_valid); // R2

  AST_HIGH_EXACT: assert property (@(posedge clk) disable iff (rst)
    in_valid |=> (p[PW-1:2] == $past(exact_w[PW-1:2]))); // R3

  AST_ERR_BOUND: assert property (@(posedge clk) disable iff (rst)
    in_valid |=> (($signed(p - $past(exact_w)) <= 3) &&
                  ($signed(p - $past(exact_w)) >= -3))); // R4

  AST_POS_ROW_EXACT: assert property (@(posedge clk) disable iff (rst)
    (in_valid && !row_neg[0]) |=> (p == $past(exact_w))); // R6

  AST_HOLD_IDLE: assert property (@(posedge clk) disable iff (rst)
    !in_valid |=> $stable(p)); // R8

endmodule

bind apx_booth_mul apx_booth_mul_chk #(.W(W)) u_chk (
  .clk      (clk),
  .rst      (rst),
  .in_valid (in_valid),
  .a        (a),
  .b        (b),
  .out_valid(out_valid),
  .p        (p),
  .row_neg  (negs)
);

// File: tb/apx_booth_mul_tb.sv
`timescale 1ns/1ps
module apx_booth_mul_tb;

  typedef struct packed {
    logic [7:0] x;
    logic [7:0] y;
  } pair_t;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        in_valid = 1'b0;
  logic [7:0]  a = 8'h00;
  logic [7:0]  b = 8'h00;
  logic        out_valid;
  logic [15:0] p;

  pair_t       sbq[$];
  int          n_chk = 0;
  int          n_fail = 0;
  int          n_res = 0;
  longint      err_sum = 0;
  logic        iv_q = 1'b0;
  logic [15:0] last_p = 16'h0000;

  always #2.5 clk = ~clk;

  apx_booth_mul #(.W(8)) u_dut (
    .clk      (clk),
    .rst      (rst),
    .in_valid (in_valid),
    .a        (a),
    .b        (b),
    .out_valid(out_valid),
    .p        (p)
  );

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic drive(input logic [7:0] x, input logic [7:0] y);
    pair_t it;
    @(negedge clk);
    in_valid = 1'b1;
    a        = x;
    b        = y;
    it.x     = x;
    it.y     = y;
    sbq.push_back(it);
  endtask

  task automatic idle();
    @(negedge clk);
    in_valid = 1'b0;
    a        = ~a;
    b        = b + 8'd37;
  endtask

  // Bench model of the valid pipeline.
  always @(posedge clk) iv_q <= rst ? 1'b0 : in_valid;

  // Monitor: pops expected pairs and compares the registered result.
  always @(negedge clk) begin
    pair_t it;
    int ex, ps, er, d0, lo;
    logic [15:0] ex16;
    #1;
    if (!rst) begin
      check(out_valid == iv_q, "R2 out_valid timing", int'(out_valid), int'(iv_q));
      if (out_valid) begin
        if (sbq.size() == 0) begin
          check(1'b0, "R2 result with no pending pair", 1, 0);
        end else begin
          it   = sbq.pop_front();
          ex   = int'($signed(it.x)) * int'($signed(it.y));
          ex16 = ex[15:0];
          ps   = int'($signed(p));
          er   = ps - ex;
          check(p[15:2] == ex16[15:2], "R3 upper bits", int'(p[15:2]), int'(ex16[15:2]));
          check((er <= 3) && (er >= -3), "R4 error bound", ps, ex);
          err_sum += (er < 0) ? -er : er;
          n_res++;
          d0 = int'(it.y[0]) - 2 * int'(it.y[1]);
          lo = int'($signed(it.x)) * d0 - int'(it.y[1]);
          check(p[1:0] == lo[1:0], "R5 low bits", int'(p[1:0]), int'(lo[1:0]));
          if (!it.y[1]) begin
            check(ps == ex, "R6 exact for non-negative first digit", ps, ex);
          end
          if (it.x == 8'h80 && it.y == 8'h7F) begin
            check(p == 16'hC083, "R4 corner -128 x 127", int'(p), 32'hC083);
          end
          if (it.x == 8'h80 && it.y == 8'h80) begin
            check(p == 16'h4000, "R6 corner -128 x -128", int'(p), 32'h4000);
          end
        end
      end else begin
        check(p == last_p, "R8 hold while idle", int'(p), int'(last_p));
      end
      last_p = p;
    end
  end

  initial begin
    repeat (4) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    #1;
    check(!out_valid, "R1 out_valid after reset", int'(out_valid), 0);
    check(p == 16'h0000, "R1 p after reset", int'(p), 0);
    for (int i = 0; i < 256; i++) begin
      for (int j = 0; j < 256; j++) begin
        drive(i[7:0], j[7:0]);
      end
      idle();
    end
    repeat (3) idle();
    #2;
    check(sbq.size() == 0, "R2 all pairs answered", sbq.size(), 0);
    check(n_res == 65536, "R2 result count", n_res, 65536);
    check(err_sum * 10 <= 64'd16 * 65536, "R7 mean error x65536", int'(err_sum), 104857);
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    n_fail++;
    $display("FAIL R2 watchdog expired actual=%0d expected=%0d", n_res, 65536);
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end

endmodule